// File: doc/BRIEF.md
# Fixed-Point Status Flag Unit

This block keeps the status flags that an integer datapath sets as a side effect of an operation. The flags are carry, 32-bit carry, overflow, 32-bit overflow, sticky summary overflow, and a 4-bit condition field. The execution stage gives it the operands it used and the result it produced. It can also give an immediate operand, an instruction to complement the first operand, and an overflow verdict from the divider. Per-instruction enables then say which flag groups this operation may change. The arithmetic itself happens elsewhere; this unit only derives flags from the values it is shown.

Each accepted operation (`op_vld` high at a rising clock edge) updates the flag registers in that same edge, so the new flags are visible one cycle after the operation is presented. Flags that an operation is not allowed to touch keep their values. The summary overflow only ever rises; only reset clears it.

Top module: `fxflag_unit`

## Requirements
- R1: After a synchronous active-low reset, `ca`, `ca32`, `ov`, `ov32`, `so` and all four bits of `cr0` are 0.
- R2: When `inv_a` is high, the first operand is bitwise complemented before it enters any flag rule. When `imm_use` is high, `imm_val` joins the operand set. When `op_b_use` is low, `op_b` is not part of the set.
- R3: With `carry_en` high, `ca` becomes 1 exactly when some operand in the set, compared as an unsigned 64-bit value, is greater than `result`.
- R4: With `carry_en` high, `ca32` follows the rule of R3 applied only to bits 31..0 of the operands and of `result`.
- R5: `wrote_ca` high keeps `ca` unchanged, and `wrote_ca32` high keeps `ca32` unchanged, even when `carry_en` is high. Each suppression acts only on its own flag.
- R6: With `ovf_en` high and at least two operands in the set, `ov` is 1 exactly when the first two operands have equal bit 63 and `result` bit 63 differs from them. `ov32` applies the same rule to bit 31. The second operand is `op_b` when `op_b_use` is high; otherwise it is `imm_val`.
- R7: With `ovf_en` and `div_ovf_use` high, both `ov` and `ov32` take the value of `div_ovf`, and the rule of R6 is not used.
- R8: Whenever `ovf_en` causes an overflow update, `so` becomes `so | ov_new`. Once set, `so` stays 1 until reset, and `ov` = 1 implies `so` = 1.
- R9: With `rec_en` high, `cr0` is loaded as {bit 3: result negative, bit 2: result positive, bit 1: result zero, bit 0: `so` after this operation's update}. `result` is read as signed, and exactly one of bits 3..1 is 1.
- R10: With `ovf_en` high, `div_ovf_use` low and only one operand in the set, `ov`, `ov32` and `so` keep their values.
- R11: With `op_vld` low, no output changes. With `op_vld` high, `carry_en` low leaves `ca` and `ca32` unchanged, `ovf_en` low leaves `ov`, `ov32` and `so` unchanged, and `rec_en` low leaves `cr0` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_vld | input | 1 | An operation is presented this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second register operand |
| op_b_use | input | 1 | `op_b` belongs to the operand set |
| inv_a | input | 1 | Complement `op_a` before flag rules |
| imm_use | input | 1 | `imm_val` belongs to the operand set |
| imm_val | input | 64 | Immediate operand |
| result | input | 64 | Result produced by the datapath |
| carry_en | input | 1 | Operation may update carry flags |
| ovf_en | input | 1 | Operation may update overflow flags and `so` |
| rec_en | input | 1 | Operation records into `cr0` |
| div_ovf_use | input | 1 | Take overflow from `div_ovf` |
| div_ovf | input | 1 | Overflow verdict from the divider |
| wrote_ca | input | 1 | Instruction set `ca` itself; keep it |
| wrote_ca32 | input | 1 | Instruction set `ca32` itself; keep it |
| ca | output | 1 | 64-bit carry |
| ca32 | output | 1 | 32-bit carry |
| ov | output | 1 | 64-bit overflow |
| ov32 | output | 1 | 32-bit overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The assertions assume that reset is applied before the first operation and that no path other than reset clears the summary overflow. They also assume the enables are stable around the rising edge at which `op_vld` is sampled. The stimulus changes every input only on falling edges, starts each phase from a reset, and gives each operation one cycle. Idle cycles carry deliberately noisy operands, so that the hold rules are checked against inputs that would otherwise change the flags.

// File: rtl/fxflag_pkg.sv
// Package: shared definitions for the fixed-point status flag unit.
// Assumes: an operand set of at most three sources (first, second, immediate).
package fxflag_pkg;

    localparam int NUM_SRC = 3;

    // Position of each source in the operand set; the first two feed overflow.
    typedef enum logic [1:0] {
        SRC_FIRST  = 2'd0,
        SRC_SECOND = 2'd1,
        SRC_IMM    = 2'd2
    } src_idx_e;

    // Architectural flag bundle held by the unit.
    typedef struct packed {
        logic ca;
        logic ca32;
        logic ov;
        logic ov32;
        logic so;
    } xflags_t;

endpackage

// File: rtl/fxflag_operands.sv
// Module: assembles the operand set that every flag rule consumes.
// Assumes: the slot order is first, second register operand, immediate;
//          a slot whose live bit is low holds zero and is never compared.
module fxflag_operands
    import fxflag_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                          inv_first_i,
    input  logic [XLEN-1:0]               first_i,
    input  logic                          second_use_i,
    input  logic [XLEN-1:0]               second_i,
    input  logic                          imm_use_i,
    input  logic [XLEN-1:0]               imm_i,
    output logic [NUM_SRC-1:0][XLEN-1:0]  src_o,
    output logic [NUM_SRC-1:0]            live_o,
    output logic [XLEN-1:0]               ovf_x0_o,
    output logic [XLEN-1:0]               ovf_x1_o,
    output logic                          pair_o
);

    logic [XLEN-1:0] first_eff;

    // Complement the first operand when asked; all rules see this value.
    always_comb begin
        first_eff = inv_first_i ? ~first_i : first_i;
    end

    // Fill the operand slots and mark the ones that take part.
    always_comb begin
        src_o[SRC_FIRST]   = first_eff;
        src_o[SRC_SECOND]  = second_use_i ? second_i : '0;
        src_o[SRC_IMM]     = imm_use_i ? imm_i : '0;
        live_o[SRC_FIRST]  = 1'b1;
        live_o[SRC_SECOND] = second_use_i;
        live_o[SRC_IMM]    = imm_use_i;
    end

    // Pick the two operands the sign rule compares: the first, then the next live one.
    always_comb begin
        ovf_x0_o = first_eff;
        ovf_x1_o = second_use_i ? second_i : imm_i;
        pair_o   = second_use_i | imm_use_i;
    end

endmodule

// File: rtl/fxflag_carry.sv
// Module: unsigned "some operand exceeds the result" detector over W bits.
// Assumes: callers pass already-sliced operands; one instance per carry width.
module fxflag_carry #(
    parameter int W = 64,
    parameter int N = 3
) (
    input  logic [N-1:0][W-1:0] src_i,
    input  logic [N-1:0]        live_i,
    input  logic [W-1:0]        res_i,
    output logic                carry_o
);

    logic [N-1:0] above;

    // One unsigned magnitude comparator per operand slot.
    for (genvar k = 0; k < N; k++) begin : g_cmp
        assign above[k] = live_i[k] && (src_i[k] > res_i);
    end

    // Any live operand above the result signals a carry.
    always_comb begin
        carry_o = |above;
    end

endmodule

// File: rtl/fxflag_sign_ovf.sv
// Module: signed overflow from sign bits: equal input signs, different result sign.
// Assumes: the caller has chosen the two operands and the sign bit position.
module fxflag_sign_ovf (
    input  logic x0_sign_i,
    input  logic x1_sign_i,
    input  logic res_sign_i,
    output logic ovf_o
);

    // Overflow only when like-signed inputs produce an unlike-signed result.
    always_comb begin
        ovf_o = (x0_sign_i == x1_sign_i) && (res_sign_i != x0_sign_i);
    end

endmodule

// File: rtl/fxflag_cond.sv
// Module: forms the condition field from a signed result and the summary bit.
// Assumes: the summary bit given is the value after this operation's update.
module fxflag_cond #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] res_i,
    input  logic            so_i,
    output logic [3:0]      field_o
);

    logic is_zero;
    logic is_neg;

    // Classify the result: sign from the top bit, zero from the whole word.
    always_comb begin
        is_zero = (res_i == '0);
        is_neg  = res_i[XLEN-1];
    end

    // Pack {neg, pos, zero, so}; exactly one of the top three is set.
    always_comb begin
        field_o = {is_neg, ~is_neg & ~is_zero, is_zero, so_i};
    end

endmodule

// File: rtl/fxflag_unit.sv
// Module: fixed-point status flag unit. Holds the carry, overflow, summary
//         overflow and condition field registers and updates them on each
//         accepted operation according to the per-operation enables.
// Assumes: synchronous active-low reset; inputs stable around the sampling
//          edge; summary overflow is cleared only by reset.
module fxflag_unit
    import fxflag_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LOW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_vld,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic             op_b_use,
    input  logic             inv_a,
    input  logic             imm_use,
    input  logic [XLEN-1:0]  imm_val,
    input  logic [XLEN-1:0]  result,
    input  logic             carry_en,
    input  logic             ovf_en,
    input  logic             rec_en,
    input  logic             div_ovf_use,
    input  logic             div_ovf,
    input  logic             wrote_ca,
    input  logic             wrote_ca32,
    output logic             ca,
    output logic             ca32,
    output logic             ov,
    output logic             ov32,
    output logic             so,
    output logic [3:0]       cr0
);

    localparam int HI_SIGN = XLEN - 1;
    localparam int LO_SIGN = LOW_W - 1;

    logic [NUM_SRC-1:0][XLEN-1:0]  src_full;
    logic [NUM_SRC-1:0][LOW_W-1:0] src_low;
    logic [NUM_SRC-1:0]            src_live;
    logic [XLEN-1:0]               ovf_x0;
    logic [XLEN-1:0]               ovf_x1;
    logic                          have_pair;
    logic                          carry_hi;
    logic                          carry_lo;
    logic                          sgn_ovf_hi;
    logic                          sgn_ovf_lo;
    logic                          ovf_upd;
    logic                          ov_new;
    logic                          ov32_new;
    logic                          so_new;
    logic [3:0]                    cond_new;
    xflags_t                       flg_q;
    logic [3:0]                    cr0_q;

    fxflag_operands #(.XLEN(XLEN)) u_opnd (
        .inv_first_i  (inv_a),
        .first_i      (op_a),
        .second_use_i (op_b_use),
        .second_i     (op_b),
        .imm_use_i    (imm_use),
        .imm_i        (imm_val),
        .src_o        (src_full),
        .live_o       (src_live),
        .ovf_x0_o     (ovf_x0),
        .ovf_x1_o     (ovf_x1),
        .pair_o       (have_pair)
    );

    // Low-half slices of every operand slot for the 32-bit carry.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_low
        assign src_low[k] = src_full[k][LOW_W-1:0];
    end

    fxflag_carry #(.W(XLEN), .N(NUM_SRC)) u_carry_hi (
        .src_i   (src_full),
        .live_i  (src_live),
        .res_i   (result),
        .carry_o (carry_hi)
    );

    fxflag_carry #(.W(LOW_W), .N(NUM_SRC)) u_carry_lo (
        .src_i   (src_low),
        .live_i  (src_live),
        .res_i   (result[LOW_W-1:0]),
        .carry_o (carry_lo)
    );

    fxflag_sign_ovf u_ovf_hi (
        .x0_sign_i  (ovf_x0[HI_SIGN]),
        .x1_sign_i  (ovf_x1[HI_SIGN]),
        .res_sign_i (result[HI_SIGN]),
        .ovf_o      (sgn_ovf_hi)
    );

    fxflag_sign_ovf u_ovf_lo (
        .x0_sign_i  (ovf_x0[LO_SIGN]),
        .x1_sign_i  (ovf_x1[LO_SIGN]),
        .res_sign_i (result[LO_SIGN]),
        .ovf_o      (sgn_ovf_lo)
    );

    // Choose the overflow source and decide whether this operation updates it.
    always_comb begin
        ovf_upd  = ovf_en && (div_ovf_use || have_pair);
        ov_new   = div_ovf_use ? div_ovf : sgn_ovf_hi;
        ov32_new = div_ovf_use ? div_ovf : sgn_ovf_lo;
        so_new   = ovf_upd ? (flg_q.so | ov_new) : flg_q.so;
    end

    fxflag_cond #(.XLEN(XLEN)) u_cond (
        .res_i   (result),
        .so_i    (so_new),
        .field_o (cond_new)
    );

    // Carry flags: update on enable unless the instruction wrote them itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q.ca   <= 1'b0;
            flg_q.ca32 <= 1'b0;
        end else if (op_vld && carry_en) begin
            if (!wrote_ca)   flg_q.ca   <= carry_hi;
            if (!wrote_ca32) flg_q.ca32 <= carry_lo;
        end
    end

    // Overflow flags and sticky summary: update when a verdict is available.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q.ov   <= 1'b0;
            flg_q.ov32 <= 1'b0;
            flg_q.so   <= 1'b0;
        end else if (op_vld && ovf_upd) begin
            flg_q.ov   <= ov_new;
            flg_q.ov32 <= ov32_new;
            flg_q.so   <= so_new;
        end
    end

    // Condition field: load on record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr0_q <= 4'b0000;
        end else if (op_vld && rec_en) begin
            cr0_q <= cond_new;
        end
    end

    // Drive the outputs straight from the registers.
    always_comb begin
        ca   = flg_q.ca;
        ca32 = flg_q.ca32;
        ov   = flg_q.ov;
        ov32 = flg_q.ov32;
        so   = flg_q.so;
        cr0  = cr0_q;
    end

    // ---------------- assertions ----------------
    assert_ca_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && carry_en && wrote_ca) |=> $stable(ca));

    assert_ca32_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && carry_en && wrote_ca32) |=> $stable(ca32));

    assert_div_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && ovf_en && div_ovf_use) |=> (ov == ov32) && (ov == $past(div_ovf)));

    assert_so_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        so |=> so);

    assert_ov_implies_so_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ov |-> so);

    assert_cond_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && rec_en) |=> ($countones(cr0[3:1]) == 1) && (cr0[0] == so));

    assert_single_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && ovf_en && !div_ovf_use && !op_b_use && !imm_use)
        |=> $stable(ov) && $stable(ov32) && $stable(so));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> $stable({ca, ca32, ov, ov32, so, cr0}));

endmodule

// File: tb/fxflag_unit_tb.sv
// Bench: scoreboard for fxflag_unit. A driver task applies one cycle of
// stimulus and pushes the flags a reference model predicts; a monitor pops
// and compares them one cycle later, away from the clock edge.
module fxflag_unit_tb;

    typedef struct {
        logic [4:0] fl;   // {ca, ca32, ov, ov32, so}
        logic [3:0] cr;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [63:0] op_a = '0, op_b = '0, imm_val = '0, result = '0;
    logic        op_b_use = 1'b0, inv_a = 1'b0, imm_use = 1'b0;
    logic        carry_en = 1'b0, ovf_en = 1'b0, rec_en = 1'b0;
    logic        div_ovf_use = 1'b0, div_ovf = 1'b0;
    logic        wrote_ca = 1'b0, wrote_ca32 = 1'b0;
    logic        ca, ca32, ov, ov32, so;
    logic [3:0]  cr0;

    int    n_chk = 0;
    int    n_bad = 0;
    logic  drv_act = 1'b0;
    logic  done = 1'b0;
    exp_t  sb_q[$];

    // model state
    logic       m_ca, m_ca32, m_ov, m_ov32, m_so;
    logic [3:0] m_cr;

    always #2 clk = ~clk;

    fxflag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_a(op_a), .op_b(op_b),
        .op_b_use(op_b_use), .inv_a(inv_a), .imm_use(imm_use), .imm_val(imm_val),
        .result(result), .carry_en(carry_en), .ovf_en(ovf_en), .rec_en(rec_en),
        .div_ovf_use(div_ovf_use), .div_ovf(div_ovf), .wrote_ca(wrote_ca),
        .wrote_ca32(wrote_ca32), .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32),
        .so(so), .cr0(cr0)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got {ca,ca32,ov,ov32,so,cr0}=%b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: pops one expectation per driven cycle, 1 ns after the edge.
    always @(posedge clk) begin
        automatic logic act = drv_act;
        #1;
        if (act && sb_q.size() > 0) begin
            automatic exp_t e = sb_q.pop_front();
            check(e.tag, {ca, ca32, ov, ov32, so, cr0}, {e.fl, e.cr});
        end
    end

    task automatic set_in(input logic [63:0] a, input logic [63:0] b, input logic bu,
                          input logic inv, input logic iu, input logic [63:0] imm,
                          input logic [63:0] res, input logic ce, input logic oe,
                          input logic re, input logic du, input logic dv,
                          input logic wc, input logic wc32);
        op_a = a; op_b = b; op_b_use = bu; inv_a = inv; imm_use = iu; imm_val = imm;
        result = res; carry_en = ce; ovf_en = oe; rec_en = re; div_ovf_use = du;
        div_ovf = dv; wrote_ca = wc; wrote_ca32 = wc32;
    endtask

    // Driver: applies the current inputs for one cycle and predicts the flags.
    task automatic go(input logic vld, input string tag);
        logic [63:0] x0, x1;
        logic c64, c32, o64, o32;
        exp_t e;
        x0  = inv_a ? ~op_a : op_a;
        c64 = (x0 > result) | (op_b_use && (op_b > result)) | (imm_use && (imm_val > result));
        c32 = (x0[31:0] > result[31:0]) | (op_b_use && (op_b[31:0] > result[31:0]))
            | (imm_use && (imm_val[31:0] > result[31:0]));
        x1  = op_b_use ? op_b : imm_val;
        o64 = (x0[63] == x1[63]) && (result[63] != x0[63]);
        o32 = (x0[31] == x1[31]) && (result[31] != x0[31]);
        if (vld) begin
            if (carry_en && !wrote_ca)   m_ca   = c64;
            if (carry_en && !wrote_ca32) m_ca32 = c32;
            if (ovf_en && div_ovf_use) begin
                m_ov = div_ovf; m_ov32 = div_ovf; m_so = m_so | div_ovf;
            end else if (ovf_en && (op_b_use || imm_use)) begin
                m_ov = o64; m_ov32 = o32; m_so = m_so | o64;
            end
            if (rec_en)
                m_cr = {$signed(result) < 0, $signed(result) > 0, result == 64'd0, m_so};
        end
        op_vld = vld;
        e.fl = {m_ca, m_ca32, m_ov, m_ov32, m_so};
        e.cr = m_cr;
        e.tag = tag;
        sb_q.push_back(e);
        drv_act = 1'b1;
        @(negedge clk);
        drv_act = 1'b0;
        op_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        {m_ca, m_ca32, m_ov, m_ov32, m_so} = '0;
        m_cr = '0;
        check("R1 reset", {ca, ca32, ov, ov32, so, cr0}, 9'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // plain add, positive result
        set_in(64'd5, 64'd7, 1, 0, 0, 0, 64'd12, 1, 1, 1, 0, 0, 0, 0);
        go(1, "R3 no carry / R9 positive");
        // carry out of both halves
        set_in('1, 64'd2, 1, 0, 0, 0, 64'd1, 1, 1, 1, 0, 0, 0, 0);
        go(1, "R3 R4 carry both widths");
        // carry only in the low half
        set_in(64'h0000_0000_FFFF_FFFF, 64'd1, 1, 0, 0, 0, 64'h1_0000_0000, 1, 1, 1, 0, 0, 0, 0);
        go(1, "R4 low-half carry only");
        // 32-bit overflow only, summary untouched
        set_in(64'h7FFF_FFFF, 64'd1, 1, 0, 0, 0, 64'h8000_0000, 1, 1, 1, 0, 0, 0, 0);
        go(1, "R6 ov32 only, so unchanged");
        // 64-bit overflow, negative result, summary rises
        set_in(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 0, 0, 0, 64'h8000_0000_0000_0000, 1, 1, 1, 0, 0, 0, 0);
        go(1, "R6 R8 ov64 sets so / R9 negative");
        // summary stays set after a clean operation
        set_in(64'd1, 64'd1, 1, 0, 0, 0, 64'd2, 1, 1, 1, 0, 0, 0, 0);
        go(1, "R8 so sticky");
        // inverted first operand, record disabled
        set_in(64'd5, 64'd10, 1, 1, 0, 0, 64'd5, 1, 1, 0, 0, 0, 0, 0);
        go(1, "R2 inverted operand / R11 cr0 held");
        // immediate joins, second register ignored
        set_in(64'd3, '1, 0, 0, 1, '1, 64'd2, 1, 1, 1, 0, 0, 0, 0);
        go(1, "R2 immediate operand, op_b excluded");
        // zero result
        set_in(64'd0, 64'd0, 1, 0, 0, 0, 64'd0, 0, 0, 1, 0, 0, 0, 0);
        go(1, "R9 zero / R11 carry and ovf held");
        // suppression of ca only
        set_in(64'd1, 64'd1, 1, 0, 0, 0, 64'd2, 1, 0, 0, 0, 0, 1, 0);
        go(1, "R5 ca kept, ca32 updated");
        // suppression of ca32 only: would set both
        set_in('1, 64'd2, 1, 0, 0, 0, 64'd1, 1, 0, 0, 0, 0, 0, 1);
        go(1, "R5 ca32 kept, ca updated");
        // idle cycle with noisy inputs
        set_in(64'd0, '1, 1, 1, 1, '1, 64'h8000_0000_0000_0000, 1, 1, 1, 1, 1, 0, 0);
        go(0, "R11 idle hold");

        do_reset();
        // divide override on a single operand
        set_in(64'd9, 64'd0, 0, 0, 0, 0, 64'd0, 0, 1, 1, 1, 1, 0, 0);
        go(1, "R7 divide overflow sets both / R9 so bit");
        set_in(64'd9, 64'd0, 0, 0, 0, 0, 64'd3, 0, 1, 1, 1, 0, 0, 0);
        go(1, "R7 divide clear, R8 so held");

        do_reset();
        // single operand, no divide verdict: overflow flags hold
        set_in(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 0, 0, 0, 64'h8000_0000_0000_0000, 0, 1, 0, 0, 0, 0, 0);
        go(1, "R6 setup ov");
        set_in(64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 0, 0, 64'd5, 0, 1, 1, 0, 0, 0, 0);
        go(1, "R10 single operand hold");
        // overflow disabled with a pair that would overflow
        set_in(64'h7FFF_FFFF, 64'd1, 1, 0, 0, 0, 64'h8000_0000, 0, 0, 0, 0, 0, 0, 0);
        go(1, "R11 ovf disabled hold");

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule